// File: doc/BRIEF.md
# 8-bit ALU with status flags

This block is the arithmetic and logic datapath of a small 8-bit controller core. It takes one or two byte operands and a 3-bit operation code. Within the same cycle it forms the byte result, or a 16-bit result for the register-pair operation. On the next rising clock edge it merges the new status flags into a 6-bit flag register. Instruction decode picks the operation and the operands. The block does not read the register file, the multiplier or memory.

There are eight operations: byte add, byte subtract, increment, decrement, two's-complement negate, one's complement, arithmetic shift right, and a 16-bit add of a 6-bit unsigned constant to a register pair. Each operation writes only its own subset of the flags. A flag outside that subset keeps the value it had. The flag register loads only when the operation strobe is high, so idle cycles leave it unchanged.

Top module: `alu8_flags`

## Requirements
- R1: With op_sel = 0 (add), res_lo is (opa + opb) mod 256. Flag C (bit 0 of flags_q) becomes the carry out of bit 7, and flag H (bit 5) becomes the carry out of bit 3.
- R2: With op_sel = 0, flag V (bit 3) is set exactly when the signed sum of opa and opb lies outside -128..127.
- R3: With op_sel = 1 (subtract), res_lo is (opa - opb) mod 256. C is set when opa < opb unsigned. H is set when the low nibble of opa is below the low nibble of opb. V is set when the signed difference lies outside -128..127.
- R4: Every operation sets N (bit 2) to the most significant result bit and S (bit 4) to N xor V. It sets Z (bit 1) when the result is zero. For op_sel = 7 the result is the 16-bit word; for all other codes it is the byte.
- R5: With op_sel = 2 (increment), res_lo is opa + 1 mod 256. V is set only when the result is 0x80. C and H keep their previous values.
- R6: With op_sel = 3 (decrement), res_lo is opa - 1 mod 256. V is set only when the result is 0x7F. C and H keep their previous values.
- R7: With op_sel = 4 (negate), res_lo is (256 - opa) mod 256, so 0x80 stays 0x80. C is set when the result is nonzero, V is set when the result is 0x80, and H is set when the low nibble of opa is nonzero.
- R8: With op_sel = 5 (one's complement), res_lo is opa xor 0xFF. C is forced to 1 and V to 0. H keeps its previous value.
- R9: With op_sel = 6 (arithmetic shift right), res_lo is opa shifted right by one with bit 7 kept. C takes opa bit 0, V becomes N xor C, and H keeps its previous value.
- R10: With op_sel = 7 (pair add), {res_hi, res_lo} is ({pair_hi, opa} + imm) mod 65536. C is the carry out of bit 15, and V is set when bit 15 goes from 0 to 1. H keeps its previous value. For every other code res_hi is 0.
- R11: Reset clears flags_q to 0. flags_q changes only on a rising clock edge while op_valid is high. With op_valid low, all six flags hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid | input | 1 | Operation strobe; enables the flag register update |
| op_sel | input | 3 | Operation code (0 add, 1 sub, 2 inc, 3 dec, 4 neg, 5 com, 6 asr, 7 pair add) |
| opa | input | 8 | First operand; low byte of the pair for op_sel 7 |
| opb | input | 8 | Second operand for add and subtract |
| pair_hi | input | 8 | High byte of the register pair |
| imm | input | 6 | Unsigned constant for the pair add |
| res_lo | output | 8 | Result byte, or low byte of the word result |
| res_hi | output | 8 | High byte of the word result; 0 for byte operations |
| flags_q | output | 6 | Registered flags {H, S, V, N, Z, C} |

## Verification
The result outputs are combinational, so a wrong result or a badly formed word appears in the same cycle the operands are applied. A wrong flag equation appears on flags_q one edge after the strobed operation. A bad write mask can stay hidden, because it only shows when a later operation leaves that flag alone. For that reason each increment, decrement, complement and shift is preceded by an add that drives C and H to varied values. A missing hold on the flag register shows on flags_q at the first edge with op_valid low.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
    localparam int DW    = 8;
    localparam int WW    = 2 * DW;
    localparam int IMM_W = 6;
    localparam int HB    = 3;
    localparam int NFLAG = 6;

    localparam int FC = 0;
    localparam int FZ = 1;
    localparam int FN = 2;
    localparam int FV = 3;
    localparam int FS = 4;
    localparam int FH = 5;

    typedef logic [NFLAG-1:0] flag_t;

    typedef enum logic [2:0] {
        OP_ADD  = 3'd0,
        OP_SUB  = 3'd1,
        OP_INC  = 3'd2,
        OP_DEC  = 3'd3,
        OP_NEG  = 3'd4,
        OP_COM  = 3'd5,
        OP_ASR  = 3'd6,
        OP_ADDW = 3'd7
    } alu_op_e;

    localparam flag_t MASK_ALL  = '1;
    localparam flag_t MASK_STEP = flag_t'((1 << FZ) | (1 << FN) | (1 << FV) | (1 << FS));
    localparam flag_t MASK_NOH  = flag_t'((1 << FC) | (1 << FZ) | (1 << FN) | (1 << FV) | (1 << FS));
endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
    parameter int DW = 8,
    parameter int HB = 3
) (
    input  logic [DW-1:0] x,
    input  logic [DW-1:0] y,
    input  logic          sub,
    output logic [DW-1:0] r,
    output logic          c,
    output logic          h,
    output logic          v
);
    logic [DW:0]   ext;
    logic [DW-1:0] hx;

    function automatic logic borrow_bit(input logic xb, input logic yb, input logic rb);
        return (~xb & yb) | (~xb & rb) | (rb & yb);
    endfunction

    always_comb begin
        if (sub) ext = {1'b0, x} - {1'b0, y};
        else     ext = {1'b0, x} + {1'b0, y};
        r  = ext[DW-1:0];
        hx = x ^ y ^ r;
        if (sub) begin
            c = borrow_bit(x[DW-1], y[DW-1], r[DW-1]);
            h = borrow_bit(x[HB], y[HB], r[HB]);
            v = (r[DW-1] ^ x[DW-1]) & (x[DW-1] ^ y[DW-1]);
        end else begin
            c = ext[DW];
            h = hx[HB+1];
            v = (r[DW-1] ^ x[DW-1]) & ~(x[DW-1] ^ y[DW-1]);
        end
    end
endmodule

// File: rtl/alu8_unary.sv
module alu8_unary
    import alu8_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] x,
    input  alu_op_e      op,
    output logic [W-1:0] r,
    output logic         c,
    output logic         v
);
    localparam logic [W-1:0] ONE     = W'(1);
    localparam logic [W-1:0] MIN_NEG = {1'b1, {(W-1){1'b0}}};
    localparam logic [W-1:0] MAX_POS = {1'b0, {(W-1){1'b1}}};

    always_comb begin
        r = '0;
        c = 1'b0;
        v = 1'b0;
        unique case (op)
            OP_INC: begin
                r = x + ONE;
                v = (r == MIN_NEG);
            end
            OP_DEC: begin
                r = x - ONE;
                v = (r == MAX_POS);
            end
            OP_COM: begin
                r = x ^ {W{1'b1}};
                c = 1'b1;
            end
            OP_ASR: begin
                r = {x[W-1], x[W-1:1]};
                c = x[0];
                v = r[W-1] ^ x[0];
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/alu8_word.sv
module alu8_word #(
    parameter int DW    = 8,
    parameter int IMM_W = 6
) (
    input  logic [DW-1:0]    lo,
    input  logic [DW-1:0]    hi,
    input  logic [IMM_W-1:0] imm,
    output logic [2*DW-1:0]  w,
    output logic             c,
    output logic             v
);
    localparam int WW = 2 * DW;
    logic [WW:0] sum;

    always_comb begin
        sum = {1'b0, hi, lo} + {{(WW+1-IMM_W){1'b0}}, imm};
        w   = sum[WW-1:0];
        c   = sum[WW];
        v   = ~hi[DW-1] & sum[WW-1];
    end
endmodule

// File: rtl/alu8_flags.sv
module alu8_flags
    import alu8_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_valid,
    input  logic [2:0]       op_sel,
    input  logic [DW-1:0]    opa,
    input  logic [DW-1:0]    opb,
    input  logic [DW-1:0]    pair_hi,
    input  logic [IMM_W-1:0] imm,
    output logic [DW-1:0]    res_lo,
    output logic [DW-1:0]    res_hi,
    output logic [NFLAG-1:0] flags_q
);
    alu_op_e       op;
    logic [DW-1:0] as_x, as_y, as_r, un_r;
    logic          as_sub, as_c, as_h, as_v, un_c, un_v, w_c, w_v;
    logic [WW-1:0] w_r;
    flag_t         nf, mask;
    logic          msb, is_zero;

    assign op     = alu_op_e'(op_sel);
    assign as_sub = (op != OP_ADD);
    assign as_x   = (op == OP_NEG) ? '0 : opa;
    assign as_y   = (op == OP_NEG) ? opa : opb;

    alu8_addsub #(.DW(DW), .HB(HB)) u_addsub (
        .x(as_x), .y(as_y), .sub(as_sub), .r(as_r), .c(as_c), .h(as_h), .v(as_v)
    );

    alu8_unary #(.W(DW)) u_unary (
        .x(opa), .op(op), .r(un_r), .c(un_c), .v(un_v)
    );

    alu8_word #(.DW(DW), .IMM_W(IMM_W)) u_word (
        .lo(opa), .hi(pair_hi), .imm(imm), .w(w_r), .c(w_c), .v(w_v)
    );

    always_comb begin
        res_lo = '0;
        res_hi = '0;
        nf     = '0;
        mask   = '0;
        unique case (op)
            OP_ADD, OP_SUB, OP_NEG: begin
                res_lo = as_r;
                nf[FC] = as_c;
                nf[FH] = as_h;
                nf[FV] = as_v;
                mask   = MASK_ALL;
            end
            OP_INC, OP_DEC: begin
                res_lo = un_r;
                nf[FV] = un_v;
                mask   = MASK_STEP;
            end
            OP_COM, OP_ASR: begin
                res_lo = un_r;
                nf[FC] = un_c;
                nf[FV] = un_v;
                mask   = MASK_NOH;
            end
            OP_ADDW: begin
                res_lo = w_r[DW-1:0];
                res_hi = w_r[WW-1:DW];
                nf[FC] = w_c;
                nf[FV] = w_v;
                mask   = MASK_NOH;
            end
            default: ;
        endcase
        msb     = (op == OP_ADDW) ? w_r[WW-1] : res_lo[DW-1];
        is_zero = (op == OP_ADDW) ? (w_r == '0) : (res_lo == '0);
        nf[FZ]  = is_zero;
        nf[FN]  = msb;
        nf[FS]  = msb ^ nf[FV];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        flags_q <= '0;
        else if (op_valid) flags_q <= (flags_q & ~mask) | (nf & mask);
    end
endmodule

// File: rtl/alu8_chk.sv
module alu8_chk
    import alu8_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             op_valid,
    input logic [2:0]       op_sel,
    input logic [DW-1:0]    res_lo,
    input logic [NFLAG-1:0] flags_q
);
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> $stable(flags_q)) else $error("idle hold");                      // R11

    AST_SIGN_XOR: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> (flags_q[FS] == (flags_q[FN] ^ flags_q[FV]))) else $error("sign"); // R4

    AST_ZERO_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_sel != 3'd7) |=> (flags_q[FZ] == ($past(res_lo) == '0))) else $error("zero"); // R4

    AST_STEP_KEEP_C: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && (op_sel == 3'd2 || op_sel == 3'd3)) |=> (flags_q[FC] == $past(flags_q[FC]))) else $error("step C"); // R5

    AST_COM_CV: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_sel == 3'd5) |=> (flags_q[FC] && !flags_q[FV])) else $error("com C V"); // R8

    AST_KEEP_H: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_sel != 3'd0 && op_sel != 3'd1 && op_sel != 3'd4)
        |=> (flags_q[FH] == $past(flags_q[FH]))) else $error("keep H");               // R9
endmodule

bind alu8_flags alu8_chk u_chk (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_sel(op_sel),
    .res_lo(res_lo), .flags_q(flags_q)
);

// File: tb/sim_alu8_flags.sv
module sim_alu8_flags;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       op_valid = 1'b0;
    logic [2:0] op_sel = '0;
    logic [7:0] opa = '0, opb = '0, pair_hi = '0;
    logic [5:0] imm = '0;
    logic [7:0] res_lo, res_hi;
    logic [5:0] flags_q;

    int n_run = 0;
    int n_fail = 0;
    int exp_f = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    alu8_flags u0 (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_sel(op_sel),
        .opa(opa), .opb(opb), .pair_hi(pair_hi), .imm(imm),
        .res_lo(res_lo), .res_hi(res_hi), .flags_q(flags_q)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    function automatic int sx(input int v);
        return (v > 127) ? v - 256 : v;
    endfunction

    function automatic string op_tag(input int op);
        case (op)
            0: return "R1 R2 R4 add";
            1: return "R3 R4 sub";
            2: return "R5 inc";
            3: return "R6 dec";
            4: return "R7 neg";
            5: return "R8 com";
            6: return "R9 asr";
            default: return "R10 pair add";
        endcase
    endfunction

    // One operation per clock: result checked mid-cycle, flags after the edge.
    task automatic run_op(input int op, input int a, input int b, input int hi, input int k);
        int lo, eh, c, z, n, v, h, m, nf, s, w;
        @(negedge clk);
        op_sel = op[2:0]; opa = a[7:0]; opb = b[7:0]; pair_hi = hi[7:0]; imm = k[5:0];
        op_valid = 1'b1;
        #1;
        c = 0; v = 0; h = 0; eh = 0; m = 31; lo = 0; n = 0; z = 0;
        case (op)
            0: begin
                s = a + b; lo = s & 255; c = (s > 255);
                h = (((a & 15) + (b & 15)) > 15);
                s = sx(a) + sx(b); v = (s > 127 || s < -128); m = 63;
            end
            1: begin
                lo = (a - b) & 255; c = (a < b); h = ((a & 15) < (b & 15));
                s = sx(a) - sx(b); v = (s > 127 || s < -128); m = 63;
            end
            2: begin lo = (a + 1) & 255; v = (a == 127); m = 30; end
            3: begin lo = (a + 255) & 255; v = (a == 128); m = 30; end
            4: begin
                lo = (256 - a) & 255; c = (a != 0); v = (a == 128);
                h = ((a & 15) != 0); m = 63;
            end
            5: begin lo = 255 - a; c = 1; v = 0; end
            6: begin lo = (a >> 1) | (a & 128); c = a & 1; v = (lo >> 7) ^ c; end
            default: begin
                w = hi * 256 + a + k; c = (w > 65535); w = w & 65535;
                lo = w & 255; eh = w >> 8;
                v = (hi < 128) && (w >= 32768);
                n = w >> 15; z = (w == 0);
            end
        endcase
        if (op != 7) begin n = lo >> 7; z = (lo == 0); end
        nf = c | (z << 1) | (n << 2) | (v << 3) | ((n ^ v) << 4) | (h << 5);
        chk(res_lo == lo[7:0], op_tag(op), res_lo, lo);
        chk(res_hi == eh[7:0], "R10 res_hi", res_hi, eh);
        exp_f = (exp_f & ~m) | (nf & m);
        @(posedge clk);
        #1;
        chk(flags_q == exp_f[5:0], {op_tag(op), " R11 flags"}, flags_q, exp_f);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk(flags_q == 6'd0, "R11 reset", flags_q, 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 R2: exhaustive add
        for (int a = 0; a < 256; a++)
            for (int b = 0; b < 256; b++) run_op(0, a, b, 0, 0);
        // R3: exhaustive subtract
        for (int a = 0; a < 256; a++)
            for (int b = 0; b < 256; b++) run_op(1, a, b, 0, 0);
        // R5 R6 R8 R9 R7: each preceded by an add that scrambles C and H
        for (int op = 2; op < 7; op++)
            for (int a = 0; a < 256; a++) begin
                run_op(0, a, a ^ 8'h5A, 0, 0);
                run_op(op, a, 0, 0, 0);
            end
        // R10: pair add sweep across carry and sign boundaries
        for (int hs = 0; hs < 4; hs++)
            for (int a = 0; a < 256; a++)
                for (int ks = 0; ks < 4; ks++)
                    run_op(7, a, 0, (hs == 0) ? 8'h00 : (hs == 1) ? 8'h7F : (hs == 2) ? 8'h80 : 8'hFF,
                           (ks == 0) ? 0 : (ks == 1) ? 1 : (ks == 2) ? 32 : 63);

        // R11: strobe low, flags must hold under changing inputs
        run_op(1, 0, 1, 0, 0);
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            op_valid = 1'b0; op_sel = i[2:0]; opa = 8'(i * 17); opb = 8'(i * 5);
            @(posedge clk);
            #1;
            chk(flags_q == exp_f[5:0], "R11 idle hold", flags_q, exp_f);
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (199000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_run++;
            $display("FAIL watchdog: actual hung expected done");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule